// File: doc/BRIEF.md
# Micro-op Dispatch Gate

This block sits between an in-order instruction fetch window and an out-of-order scheduler. Each cycle it looks at up to `SLOTS` instruction descriptors, oldest in slot 0. Each descriptor carries three numbers: its micro-op count, the reorder-buffer entries it needs, and the rename registers it needs. The block decides how many leading descriptors move on. A descriptor moves only if four things hold: it fits the cycle's micro-op budget, the reorder buffer has room for it, the rename pool has room for it, and the scheduler accepts it. The first descriptor that fails any of these ends the group for that cycle.

The micro-op budget is `DISP_W` per cycle. An instruction wider than the budget can still go when it meets a fresh, untouched budget. It then consumes the whole budget and leaves a debt that shrinks the budget of the following cycles. Every cycle the block also reports one code that explains why dispatch stopped.

Both sides use valid/ready handshakes. On the fetch side, slot i is taken when `in_valid[i] && in_ready[i]`. `in_ready` is always a contiguous run starting at slot 0. The fetch side must hold every untaken descriptor and present it again, still in age order, on a later cycle. On the scheduler side, `out_valid[i]` offers the descriptor on `out_*[i]`, and `sched_ready[i]` is the scheduler's accept for that slot. `sched_ready[i]` may depend on the offered descriptor and on older slots, but not on any younger slot.

Top module: `dispatch_gate`

## Requirements
- R1: Slot i is consumed only when `in_valid[i]` and `in_ready[i]` are both high. `in_ready` always has the form of bits 0..k-1 set and every higher bit clear.
- R2: At the start of a cycle, the available budget is `DISP_W - debt` when the debt is below `DISP_W`, and 0 otherwise.
- R3: A descriptor passes the budget check when its micro-op count is at most the remaining budget, or when the remaining budget still equals `DISP_W`. A descriptor that passes lowers the remaining budget by its count.
- R4: When a descriptor passes with a count larger than the remaining budget, the difference is added to the debt and the remaining budget becomes 0.
- R5: Between cycles, the debt drops by `DISP_W` and does not go below 0. When no descriptor consumes budget and the debt is at least `DISP_W`, the debt falls by exactly `DISP_W` per cycle.
- R6: A descriptor passes the reorder-buffer check when its entry need is at most `rob_free` minus the needs of the older descriptors dispatched in the same cycle.
- R7: A descriptor passes the rename check when its register need is at most `ren_free` minus the needs of the older descriptors dispatched in the same cycle.
- R8: `out_valid[i]` is high only when slot i is valid, passes the budget, reorder-buffer and rename checks, and every older slot is dispatched. The slot is dispatched only if `sched_ready[i]` is also high.
- R9: Dispatch is strictly in order. The first slot that is invalid, fails a check, or is refused by the scheduler ends the cycle's group. Every younger slot then has `in_ready` low, even if it would pass on its own.
- R10: `stall_code` reports the blocked slot: 0 when no valid slot is blocked, 1 for budget, 2 for reorder buffer, 3 for rename, 4 for scheduler refusal. When a slot fails several checks, the lowest nonzero code wins.
- R11: A synchronous reset clears the debt, so the first cycle after reset has the full `DISP_W` budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | SLOTS | Descriptor present, per slot (slot 0 oldest) |
| in_uops | input | SLOTS x UOP_W | Micro-op count, per slot |
| in_rob_need | input | SLOTS x ROBN_W | Reorder-buffer entries needed, per slot |
| in_ren_need | input | SLOTS x RENN_W | Rename registers needed, per slot |
| in_ready | output | SLOTS | Slot consumed this cycle |
| rob_free | input | ROBF_W | Free reorder-buffer entries |
| ren_free | input | RENF_W | Free rename registers |
| out_valid | output | SLOTS | Descriptor offered to the scheduler |
| out_uops | output | SLOTS x UOP_W | Offered micro-op counts |
| out_rob_need | output | SLOTS x ROBN_W | Offered reorder-buffer needs |
| out_ren_need | output | SLOTS x RENN_W | Offered rename needs |
| sched_ready | input | SLOTS | Scheduler accept, per slot |
| stall_code | output | 3 | Reason dispatch stopped this cycle |

## Verification
Directed cycles first cover the simple cases one at a time: a budget filled exactly, an oversized descriptor followed by its multi-cycle drain, a group limited by the reorder buffer, a group limited by the rename pool, a scheduler refusal in the middle of the group, and a gap in the valid slots. Each of these has exactly one possible limiting factor, so a wrong stall code or a wrong group length points to a single check. A long pseudo-random sweep then mixes small and oversized counts, scarce free counts and sparse scheduler accepts. The bench keeps its own arithmetic model of the debt across cycles. This separates mistakes in the carry arithmetic, which show up as wrong budgets several cycles later, from mistakes in the per-cycle group logic, which show up at once.

// File: rtl/dg_pkg.sv
package dg_pkg;
  typedef enum logic [2:0] {
    STALL_NONE   = 3'd0,
    STALL_BUDGET = 3'd1,
    STALL_ROB    = 3'd2,
    STALL_REN    = 3'd3,
    STALL_SCHED  = 3'd4
  } stall_e;
endpackage

// File: rtl/dg_budget_start.sv
// Turns the debt left from earlier cycles into this cycle's opening budget
// and the debt that remains after this cycle's share is paid off.
module dg_budget_start #(
  parameter int DISP_W = 4,
  parameter int CAR_W  = 4,
  localparam int AV_W  = $clog2(DISP_W + 1)
) (
  input  logic [CAR_W-1:0] carry_q,
  output logic [AV_W-1:0]  avail0,
  output logic [CAR_W-1:0] carry_dec
);
  localparam logic [CAR_W-1:0] W_C = CAR_W'(DISP_W);
  localparam logic [AV_W-1:0]  W_A = AV_W'(DISP_W);

  always_comb begin
    if (carry_q >= W_C) begin
      avail0    = '0;
      carry_dec = carry_q - W_C;
    end else begin
      avail0    = W_A - AV_W'(carry_q);
      carry_dec = '0;
    end
  end
endmodule

// File: rtl/dg_slot.sv
// One link of the in-order chain: local checks, scheduler query,
// resource consumption and stall reason for a single slot.
module dg_slot
  import dg_pkg::*;
#(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int ROBN_W = 4,
  parameter int RENN_W = 2,
  parameter int ROBF_W = 6,
  parameter int RENF_W = 5,
  localparam int AV_W  = $clog2(DISP_W + 1)
) (
  input  logic              go_in,
  input  logic              valid,
  input  logic [UOP_W-1:0]  uops,
  input  logic [ROBN_W-1:0] rob_need,
  input  logic [RENN_W-1:0] ren_need,
  input  logic [AV_W-1:0]   avail_in,
  input  logic [ROBF_W-1:0] rob_left_in,
  input  logic [RENF_W-1:0] ren_left_in,
  input  logic              sched_ready,
  output logic              query,
  output logic              fire,
  output logic [AV_W-1:0]   avail_out,
  output logic [ROBF_W-1:0] rob_left_out,
  output logic [RENF_W-1:0] ren_left_out,
  output logic [UOP_W-1:0]  excess,
  output stall_e            stall
);
  localparam logic [AV_W-1:0] W_A = AV_W'(DISP_W);

  logic oversize, fits, rob_ok, ren_ok;

  always_comb begin
    oversize = 32'(uops) > 32'(avail_in);
    fits     = !oversize || (avail_in == W_A);
    rob_ok   = 32'(rob_need) <= 32'(rob_left_in);
    ren_ok   = 32'(ren_need) <= 32'(ren_left_in);
    query    = go_in && valid && fits && rob_ok && ren_ok;
    fire     = query && sched_ready;
  end

  always_comb begin
    avail_out    = oversize ? '0 : avail_in - AV_W'(uops);
    excess       = (fire && oversize) ? uops - UOP_W'(avail_in) : '0;
    rob_left_out = rob_left_in - ROBF_W'(rob_need);
    ren_left_out = ren_left_in - RENF_W'(ren_need);
  end

  always_comb begin
    if (!go_in || !valid || fire) stall = STALL_NONE;
    else if (!fits)               stall = STALL_BUDGET;
    else if (!rob_ok)             stall = STALL_ROB;
    else if (!ren_ok)             stall = STALL_REN;
    else                          stall = STALL_SCHED;
  end
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
  import dg_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int ROBN_W = 4,
  parameter int RENN_W = 2,
  parameter int ROBF_W = 6,
  parameter int RENF_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SLOTS-1:0]             in_valid,
  input  logic [SLOTS-1:0][UOP_W-1:0]  in_uops,
  input  logic [SLOTS-1:0][ROBN_W-1:0] in_rob_need,
  input  logic [SLOTS-1:0][RENN_W-1:0] in_ren_need,
  output logic [SLOTS-1:0]             in_ready,
  input  logic [ROBF_W-1:0]            rob_free,
  input  logic [RENF_W-1:0]            ren_free,
  output logic [SLOTS-1:0]             out_valid,
  output logic [SLOTS-1:0][UOP_W-1:0]  out_uops,
  output logic [SLOTS-1:0][ROBN_W-1:0] out_rob_need,
  output logic [SLOTS-1:0][RENN_W-1:0] out_ren_need,
  input  logic [SLOTS-1:0]             sched_ready,
  output logic [2:0]                   stall_code
);
  localparam int AV_W  = $clog2(DISP_W + 1);
  localparam int CAR_W = UOP_W;  // debt never exceeds the largest count

  logic [CAR_W-1:0] carry_q, carry_dec, carry_d;
  logic [AV_W-1:0]  avail0;

  logic [SLOTS:0]    go_c;
  logic [AV_W-1:0]   av_c  [SLOTS+1];
  logic [ROBF_W-1:0] rob_c [SLOTS+1];
  logic [RENF_W-1:0] ren_c [SLOTS+1];
  logic [UOP_W-1:0]  exc   [SLOTS];
  stall_e            st    [SLOTS];

  dg_budget_start #(.DISP_W(DISP_W), .CAR_W(CAR_W)) u_start (
    .carry_q   (carry_q),
    .avail0    (avail0),
    .carry_dec (carry_dec)
  );

  assign go_c[0]  = 1'b1;
  assign av_c[0]  = avail0;
  assign rob_c[0] = rob_free;
  assign ren_c[0] = ren_free;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    dg_slot #(
      .DISP_W(DISP_W), .UOP_W(UOP_W), .ROBN_W(ROBN_W), .RENN_W(RENN_W),
      .ROBF_W(ROBF_W), .RENF_W(RENF_W)
    ) u_slot (
      .go_in        (go_c[i]),
      .valid        (in_valid[i]),
      .uops         (in_uops[i]),
      .rob_need     (in_rob_need[i]),
      .ren_need     (in_ren_need[i]),
      .avail_in     (av_c[i]),
      .rob_left_in  (rob_c[i]),
      .ren_left_in  (ren_c[i]),
      .sched_ready  (sched_ready[i]),
      .query        (out_valid[i]),
      .fire         (go_c[i+1]),
      .avail_out    (av_c[i+1]),
      .rob_left_out (rob_c[i+1]),
      .ren_left_out (ren_c[i+1]),
      .excess       (exc[i]),
      .stall        (st[i])
    );
  end

  assign in_ready     = go_c[SLOTS:1];
  assign out_uops     = in_uops;
  assign out_rob_need = in_rob_need;
  assign out_ren_need = in_ren_need;

  // At most one slot per cycle is both live and blocked, and at most one
  // slot can overrun the budget, so plain OR and sum are exact.
  always_comb begin
    logic [2:0]       acc;
    logic [UOP_W-1:0] exc_sum;
    acc     = '0;
    exc_sum = '0;
    for (int i = 0; i < SLOTS; i++) begin
      acc     = acc | st[i];
      exc_sum = exc_sum + exc[i];
    end
    stall_code = acc;
    carry_d    = carry_dec + CAR_W'(exc_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) carry_q <= '0;
    else     carry_q <= carry_d;
  end
endmodule

// File: rtl/dispatch_gate_chk.sv
module dispatch_gate_chk #(
  parameter int SLOTS  = 4,
  parameter int DISP_W = 4,
  parameter int CAR_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [SLOTS-1:0] in_valid,
  input logic [SLOTS-1:0] in_ready,
  input logic [SLOTS-1:0] out_valid,
  input logic [SLOTS-1:0] sched_ready,
  input logic [2:0]       stall_code,
  input logic [CAR_W-1:0] carry_q
);
  logic [SLOTS-1:0] vpre, rdy_inc;

  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      run     = run & in_valid[i];
      vpre[i] = run;
    end
    rdy_inc = in_ready + SLOTS'(1);
  end

  AST_READY_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (rdy_inc & in_ready) == '0);  // R1
  AST_READY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~(in_valid & out_valid & sched_ready)) == '0);  // R8
  AST_OFFER_AFTER_OLDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid & ~{in_ready[SLOTS-2:0], 1'b1}) == '0);  // R9
  AST_DEBT_DRAIN: assert property (@(posedge clk) disable iff (rst)
    carry_q >= CAR_W'(DISP_W) |=> carry_q == $past(carry_q) - CAR_W'(DISP_W));  // R5
  AST_NONE_MEANS_DRAINED: assert property (@(posedge clk) disable iff (rst)
    stall_code == 3'd0 |-> in_ready == vpre);  // R10
  AST_STALL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    stall_code <= 3'd4);  // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> carry_q == '0);  // R11
endmodule

bind dispatch_gate dispatch_gate_chk #(
  .SLOTS(SLOTS), .DISP_W(DISP_W), .CAR_W(UOP_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .sched_ready (sched_ready),
  .stall_code  (stall_code),
  .carry_q     (carry_q)
);

// File: tb/dispatch_gate_bench.sv
module dispatch_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS  = 4;
  localparam int DISP_W = 4;
  localparam int UOP_W  = 4;
  localparam int ROBN_W = 4;
  localparam int RENN_W = 2;
  localparam int ROBF_W = 6;
  localparam int RENF_W = 5;

  logic                         clk = 1'b0;
  logic                         rst = 1'b1;
  logic [SLOTS-1:0]             in_valid = '0;
  logic [SLOTS-1:0][UOP_W-1:0]  in_uops = '0;
  logic [SLOTS-1:0][ROBN_W-1:0] in_rob_need = '0;
  logic [SLOTS-1:0][RENN_W-1:0] in_ren_need = '0;
  logic [SLOTS-1:0]             in_ready;
  logic [ROBF_W-1:0]            rob_free = '0;
  logic [RENF_W-1:0]            ren_free = '0;
  logic [SLOTS-1:0]             out_valid;
  logic [SLOTS-1:0][UOP_W-1:0]  out_uops;
  logic [SLOTS-1:0][ROBN_W-1:0] out_rob_need;
  logic [SLOTS-1:0][RENN_W-1:0] out_ren_need;
  logic [SLOTS-1:0]             sched_ready = '0;
  logic [2:0]                   stall_code;

  int checks = 0;
  int errors = 0;
  int carry_m = 0;
  bit done = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dispatch_gate #(
    .SLOTS(SLOTS), .DISP_W(DISP_W), .UOP_W(UOP_W), .ROBN_W(ROBN_W),
    .RENN_W(RENN_W), .ROBF_W(ROBF_W), .RENF_W(RENF_W)
  ) u_dispatch_gate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
    .in_rob_need(in_rob_need), .in_ren_need(in_ren_need), .in_ready(in_ready),
    .rob_free(rob_free), .ren_free(ren_free), .out_valid(out_valid),
    .out_uops(out_uops), .out_rob_need(out_rob_need), .out_ren_need(out_ren_need),
    .sched_ready(sched_ready), .stall_code(stall_code)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  task automatic clear_inputs();
    in_valid    = '0;
    in_uops     = '0;
    in_rob_need = '0;
    in_ren_need = '0;
    rob_free    = ROBF_W'(40);
    ren_free    = RENF_W'(20);
    sched_ready = '1;
  endtask

  task automatic put(input int i, input int u, input int rn, input int nn);
    in_valid[i]    = 1'b1;
    in_uops[i]     = UOP_W'(u);
    in_rob_need[i] = ROBN_W'(rn);
    in_ren_need[i] = RENN_W'(nn);
  endtask

  // Expected values follow the requirements; checked at the falling edge,
  // the debt model advances at the rising edge.
  task automatic run_cycle(input string tag);
    int avail, cdec, robl, renl, exc, est, u;
    bit go, fit;
    logic [SLOTS-1:0] erdy, eov;
    if (carry_m >= DISP_W) begin avail = 0; cdec = carry_m - DISP_W; end
    else begin avail = DISP_W - carry_m; cdec = 0; end
    robl = int'(rob_free); renl = int'(ren_free);
    exc = 0; est = 0; go = 1'b1; erdy = '0; eov = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (go) begin
        if (!in_valid[i]) go = 1'b0;
        else begin
          u   = int'(in_uops[i]);
          fit = (u <= avail) || (avail == DISP_W);
          if (!fit) begin est = 1; go = 1'b0; end
          else if (int'(in_rob_need[i]) > robl) begin est = 2; go = 1'b0; end
          else if (int'(in_ren_need[i]) > renl) begin est = 3; go = 1'b0; end
          else begin
            eov[i] = 1'b1;
            if (!sched_ready[i]) begin est = 4; go = 1'b0; end
            else begin
              erdy[i] = 1'b1;
              if (u > avail) begin exc = exc + u - avail; avail = 0; end
              else avail = avail - u;
              robl = robl - int'(in_rob_need[i]);
              renl = renl - int'(in_ren_need[i]);
            end
          end
        end
      end
    end
    @(negedge clk);
    chk(tag, "in_ready", int'(in_ready), int'(erdy));
    chk(tag, "out_valid", int'(out_valid), int'(eov));
    chk(tag, "stall_code", int'(stall_code), est);
    @(posedge clk);
    carry_m = cdec + exc;
    #1;
  endtask

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    carry_m = 0;

    // R11: first cycle after reset has the whole budget
    clear_inputs();
    for (int i = 0; i < SLOTS; i++) put(i, 1, 1, 0);
    run_cycle("R11");
    clear_inputs(); put(0, 4, 1, 0); put(1, 1, 1, 0);
    run_cycle("R11");
    // R3: exact fill, then the next slot is out of budget
    clear_inputs(); put(0, 2, 1, 0); put(1, 2, 1, 0); put(2, 1, 1, 0);
    run_cycle("R3");
    // R4: oversized descriptor takes a fresh budget, leaves debt 7
    clear_inputs(); put(0, 11, 2, 1); put(1, 1, 1, 0);
    run_cycle("R4");
    // R5: debt 7 -> zero budget this cycle, debt 3 after
    clear_inputs(); put(0, 1, 1, 0); put(1, 1, 1, 0);
    run_cycle("R5");
    // R2: debt 3 -> budget 1
    clear_inputs(); put(0, 1, 1, 0); put(1, 1, 1, 0);
    run_cycle("R2");
    // R6: reorder-buffer room for only the first
    clear_inputs(); rob_free = ROBF_W'(3); put(0, 1, 2, 0); put(1, 1, 2, 0);
    run_cycle("R6");
    // R7: rename room for only the first
    clear_inputs(); ren_free = RENF_W'(1); put(0, 1, 1, 1); put(1, 1, 1, 1);
    run_cycle("R7");
    // R8: scheduler refuses slot 1
    clear_inputs(); for (int i = 0; i < SLOTS; i++) put(i, 1, 1, 0);
    sched_ready = 4'b1101;
    run_cycle("R8");
    // R9: a gap ends the group, younger valid slot ignored
    clear_inputs(); put(0, 1, 1, 0); put(1, 1, 1, 0); put(3, 1, 1, 0);
    run_cycle("R9");
    // R10: budget beats reorder buffer, reorder buffer beats rename
    clear_inputs(); rob_free = ROBF_W'(1); put(0, 3, 1, 0); put(1, 2, 5, 0);
    run_cycle("R10");
    clear_inputs(); rob_free = ROBF_W'(0); ren_free = RENF_W'(0); put(0, 1, 1, 1);
    run_cycle("R10");
    // R1: valid/ready with nothing valid
    clear_inputs();
    run_cycle("R1");

    // Sweep: mixed counts, scarce resources, sparse accepts
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      clear_inputs();
      for (int i = 0; i < SLOTS; i++) begin
        r = rnd();
        in_valid[i]    = (r[3:0] != 4'd0);
        in_uops[i]     = (r[6:4] == 3'd0) ? UOP_W'(5 + (r[11:8] % 11)) : UOP_W'(1 + r[13:12]);
        in_rob_need[i] = ROBN_W'(r[15:14]);
        in_ren_need[i] = RENN_W'(r[17:16] % 3);
        sched_ready[i] = (r[20:18] != 3'd0);
      end
      r = rnd();
      rob_free = ROBF_W'(r[3:0] % 13);
      ren_free = RENF_W'(r[6:4]);
      run_cycle("R1 R3 R4 R6 R7 R8 R9 R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule